// File: doc/BRIEF.md
# Transmit Endpoint Byte Buffer with Packet Rewind

This block is a byte-wide circular buffer that sits between device firmware and the transmit side of one USB IN endpoint. Firmware pushes bytes in one at a time. The endpoint controller pulls bytes out toward the serializer. The buffer keeps a write pointer and a read pointer, and each pointer has an extra wrap bit. From these pointers the block gives a fill level, a free-space count and full/empty indications.

A packet can be longer than the buffer. For that case, a sticky low-level warning rises whenever the fill level drops to or below a 4-bit programmable threshold, so that firmware knows it should refill. A request for a byte from an empty buffer is flagged as a sticky underrun, unless the controller marks the current byte as the packet's last. A write that finds the buffer full is dropped silently. A flush strobe empties the buffer.

For retransmission, the read position is latched when a packet starts. A retry strobe rewinds the read pointer to that latched position, so the same bytes go out again on the next IN request. A success strobe moves the latch forward. Rewind is only meaningful for packets that fit in the buffer, because free space is counted from the read pointer and not from the latch.

Top module: `txbuf_top`

## Requirements
- R1: During and after synchronous reset, the level is 0, the free count equals DEPTH, empty is 1, and the underrun flag is 0.
- R2: A write strobe while not full and not flushing stores the byte and raises the level by one. Write addresses wrap to zero after DEPTH entries.
- R3: The oldest unread byte is always visible on the read data output. A read strobe while not empty moves to the next byte. A read strobe while empty leaves the pointers unchanged.
- R4: A write strobe while the level equals DEPTH is dropped. Level, pointers and buffer contents do not change.
- R5: The free count always equals DEPTH minus the level, and full is 1 exactly when the level equals DEPTH.
- R6: A read strobe while empty, with the last-byte input low, sets the sticky underrun flag on the next cycle. With the last-byte input high, the flag is not set.
- R7: The warning flag becomes 1 on the cycle after a cycle in which the level is less than or equal to the threshold input, and it stays 1 until cleared.
- R8: A clear strobe resets both sticky flags on the next cycle. If a set condition is present in the same cycle, the set condition wins.
- R9: A flush strobe sets both pointers and the rewind latch to zero. Flush takes priority over any write, read, retry, start or success strobe in the same cycle.
- R10: A start strobe latches the read position as it was before any same-cycle read. A retry strobe restores the read pointer to the latched position and ignores a same-cycle read, start or success strobe.
- R11: A success strobe latches the read position that results after a same-cycle read, so a later retry returns to the first byte that has not been acknowledged.
- R12: A read and a write in the same cycle, on a buffer that is neither empty nor full, leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_wr | input | 1 | Firmware byte write strobe |
| fw_data | input | 8 | Firmware write byte |
| tx_rd | input | 1 | Controller byte request strobe |
| tx_last | input | 1 | Current byte is the packet's final byte |
| tx_data | output | 8 | Oldest unread byte |
| pkt_start | input | 1 | Packet start: latch read position |
| pkt_ok | input | 1 | Packet acknowledged: advance latch |
| pkt_retry | input | 1 | Packet failed: rewind read pointer |
| flush | input | 1 | Empty the buffer |
| warn_thr | input | 4 | Low-level warning threshold |
| flag_clr | input | 1 | Clear sticky flags |
| level | output | $clog2(DEPTH)+1 | Bytes held |
| free_cnt | output | $clog2(DEPTH)+1 | Bytes of free space |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level equals DEPTH |
| warn | output | 1 | Sticky low-level warning |
| underrun | output | 1 | Sticky underrun |

## Verification
The bench builds the buffer with DEPTH set to 8, and it sets the warning threshold to 2 with a 4-bit field. With only eight entries, a short test reaches full-buffer drops, several pointer wraparounds and rewinds that cross the wrap point. The threshold and DEPTH values are close to each other, so the warning rises and falls many times during mixed traffic. After the directed sequences, a pseudo-random phase mixes writes, reads, flushes, starts, successes and guarded retries. The reference model follows this mixed traffic cycle by cycle.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    localparam int BYTE_W = 8;
    localparam int THR_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // read pointer action chosen each cycle, in priority order
    typedef enum logic [1:0] {
        RP_HOLD   = 2'd0,
        RP_STEP   = 2'd1,
        RP_REWIND = 2'd2,
        RP_CLEAR  = 2'd3
    } rp_op_t;

    typedef struct packed {
        logic underrun;
        logic warn;
    } txbuf_flags_t;

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txbuf_wrptr.sv
module txbuf_wrptr #(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        wr_req,
    input  logic        full,
    output logic        wr_acc,
    output logic [AW:0] wr_ptr
);
    assign wr_acc = wr_req && !full && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush)
            wr_ptr <= '0;
        else if (wr_acc)
            wr_ptr <= wr_ptr + 1'b1;
    end
endmodule

// File: rtl/txbuf_rdptr.sv
module txbuf_rdptr
    import txbuf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        retry,
    input  logic        rd_req,
    input  logic        empty,
    input  logic        start,
    input  logic        ok,
    output logic [AW:0] rd_ptr,
    output logic [AW:0] anchor
);
    rp_op_t      op;
    logic [AW:0] rp_nxt;

    always_comb begin
        if (flush)
            op = RP_CLEAR;
        else if (retry)
            op = RP_REWIND;
        else if (rd_req && !empty)
            op = RP_STEP;
        else
            op = RP_HOLD;
    end

    always_comb begin
        case (op)
            RP_CLEAR:  rp_nxt = '0;
            RP_REWIND: rp_nxt = anchor;
            RP_STEP:   rp_nxt = rd_ptr + 1'b1;
            default:   rp_nxt = rd_ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            anchor <= '0;
        end else begin
            rd_ptr <= rp_nxt;
            if (op == RP_CLEAR)
                anchor <= '0;
            else if (op != RP_REWIND) begin
                if (start)
                    anchor <= rd_ptr;
                else if (ok)
                    anchor <= rp_nxt;
            end
        end
    end
endmodule

// File: rtl/txbuf_store.sv
module txbuf_store
    import txbuf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    localparam int ENTRIES = 1 << AW;

    byte_t cells [ENTRIES];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags
    import txbuf_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [LW-1:0]    level,
    input  logic [THR_W-1:0] thr,
    input  logic             unr_evt,
    output txbuf_flags_t     flags
);
    localparam int CW = max_w(LW, THR_W);

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] thr_x;
    logic          low;

    assign lvl_x = CW'(level);
    assign thr_x = CW'(thr);
    assign low   = (lvl_x <= thr_x);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.warn     <= (flags.warn && !clr) || low;
            flags.underrun <= (flags.underrun && !clr) || unr_evt;
        end
    end
endmodule

// File: rtl/txbuf_top.sv
module txbuf_top
    import txbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_wr,
    input  logic [7:0]    fw_data,
    input  logic          tx_rd,
    input  logic          tx_last,
    output logic [7:0]    tx_data,
    input  logic          pkt_start,
    input  logic          pkt_ok,
    input  logic          pkt_retry,
    input  logic          flush,
    input  logic [3:0]    warn_thr,
    input  logic          flag_clr,
    output logic [LW-1:0] level,
    output logic [LW-1:0] free_cnt,
    output logic          empty,
    output logic          full,
    output logic          warn,
    output logic          underrun
);
    logic [AW:0]  wr_ptr;
    logic [AW:0]  rd_ptr;
    logic [AW:0]  anchor;
    logic         wr_acc;
    logic         unr_evt;
    txbuf_flags_t flags;

    assign level    = wr_ptr - rd_ptr;
    assign free_cnt = LW'(DEPTH) - level;
    assign empty    = (level == '0);
    assign full     = (level == LW'(DEPTH));

    txbuf_wrptr #(.AW(AW)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_req (fw_wr),
        .full   (full),
        .wr_acc (wr_acc),
        .wr_ptr (wr_ptr)
    );

    txbuf_rdptr #(.AW(AW)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .retry  (pkt_retry),
        .rd_req (tx_rd),
        .empty  (empty),
        .start  (pkt_start),
        .ok     (pkt_ok),
        .rd_ptr (rd_ptr),
        .anchor (anchor)
    );

    txbuf_store #(.AW(AW)) u_mem (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (fw_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (tx_data)
    );

    assign unr_evt = tx_rd && empty && !tx_last && !flush && !pkt_retry;

    txbuf_flags #(.LW(LW)) u_flg (
        .clk     (clk),
        .rst     (rst),
        .clr     (flag_clr),
        .level   (level),
        .thr     (warn_thr),
        .unr_evt (unr_evt),
        .flags   (flags)
    );

    assign warn     = flags.warn;
    assign underrun = flags.underrun;
endmodule

// File: rtl/txbuf_chk.sv
module txbuf_chk #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          fw_wr,
    input logic          tx_rd,
    input logic          tx_last,
    input logic          pkt_retry,
    input logic          flush,
    input logic          flag_clr,
    input logic [LW-1:0] level,
    input logic [LW-1:0] free_cnt,
    input logic          empty,
    input logic          full,
    input logic          underrun
);
    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (level <= LW'(DEPTH)) && ((level + free_cnt) == LW'(DEPTH)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && fw_wr && !tx_rd && !flush && !pkt_retry) |=> full);

    // R3
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && tx_rd && !fw_wr && !flush && !pkt_retry) |=> empty);

    // R6
    underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && tx_rd && !tx_last && !flush && !pkt_retry) |=> underrun);

    // R8
    underrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !tx_rd) |=> !underrun);

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && level == '0));
endmodule

bind txbuf_top txbuf_chk #(.DEPTH(DEPTH)) u_txbuf_chk (
    .clk       (clk),
    .rst       (rst),
    .fw_wr     (fw_wr),
    .tx_rd     (tx_rd),
    .tx_last   (tx_last),
    .pkt_retry (pkt_retry),
    .flush     (flush),
    .flag_clr  (flag_clr),
    .level     (level),
    .free_cnt  (free_cnt),
    .empty     (empty),
    .full      (full),
    .underrun  (underrun)
);

// File: tb/test_txbuf_top.sv
`timescale 1ns/1ps
module test_txbuf_top;
    localparam int D  = 8;
    localparam int LW = $clog2(D) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fw_wr = 0, tx_rd = 0, tx_last = 0;
    logic [7:0]    fw_data = 0;
    logic          pkt_start = 0, pkt_ok = 0, pkt_retry = 0, flush = 0, flag_clr = 0;
    logic [3:0]    warn_thr = 4'd2;
    logic [7:0]    tx_data;
    logic [LW-1:0] level, free_cnt;
    logic          empty, full, warn, underrun;

    always #10 clk = ~clk;

    txbuf_top #(.DEPTH(D)) i_txbuf_top (
        .clk(clk), .rst(rst), .fw_wr(fw_wr), .fw_data(fw_data),
        .tx_rd(tx_rd), .tx_last(tx_last), .tx_data(tx_data),
        .pkt_start(pkt_start), .pkt_ok(pkt_ok), .pkt_retry(pkt_retry),
        .flush(flush), .warn_thr(warn_thr), .flag_clr(flag_clr),
        .level(level), .free_cnt(free_cnt), .empty(empty), .full(full),
        .warn(warn), .underrun(underrun)
    );

    int n_chk = 0, n_bad = 0;
    bit started = 0;

    // reference model: unbounded counters and a byte array
    int   m_wp = 0, m_rp = 0, m_anc = 0;
    bit   m_warn = 0, m_unr = 0;
    byte  m_mem [D];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int lvl, rp_new;
        started = 1;
        if (rst) begin
            m_wp = 0; m_rp = 0; m_anc = 0; m_warn = 0; m_unr = 0;
        end else begin
            lvl = m_wp - m_rp;
            m_warn = (m_warn && !flag_clr) || (lvl <= int'(warn_thr));
            m_unr  = (m_unr && !flag_clr) ||
                     (tx_rd && lvl == 0 && !tx_last && !flush && !pkt_retry);
            if (flush) begin
                m_wp = 0; m_rp = 0; m_anc = 0;
            end else begin
                if (fw_wr && lvl < D) begin
                    m_mem[m_wp % D] = fw_data;
                    m_wp++;
                end
                if (pkt_retry) begin
                    m_rp = m_anc;
                end else begin
                    rp_new = (tx_rd && lvl > 0) ? m_rp + 1 : m_rp;
                    if (pkt_start) m_anc = m_rp;
                    else if (pkt_ok) m_anc = rp_new;
                    m_rp = rp_new;
                end
            end
        end
    end

    always @(negedge clk) begin
        int lvl;
        if (started) begin
            lvl = m_wp - m_rp;
            chk("R2 level", int'(level), lvl);
            chk("R5 free", int'(free_cnt), D - lvl);
            chk("R5 full", int'(full), int'(lvl == D));
            chk("R3 empty", int'(empty), int'(lvl == 0));
            if (lvl > 0) chk("R3 head byte", int'(tx_data), int'(m_mem[m_rp % D]) & 255);
            chk("R7 warn", int'(warn), int'(m_warn));
            chk("R6 underrun", int'(underrun), int'(m_unr));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        fw_wr = 0; tx_rd = 0; tx_last = 0; pkt_start = 0; pkt_ok = 0;
        pkt_retry = 0; flush = 0; flag_clr = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        fw_wr = 1; fw_data = d; tick();
    endtask

    task automatic rd();
        tx_rd = 1; tick();
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        settle();
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 free", int'(free_cnt), D);
        chk("R1 underrun", int'(underrun), 0);

        // R2 fill, R4 extra write dropped
        for (int i = 0; i < D; i++) wr(8'h10 + 8'(i));
        wr(8'hEE);
        settle();
        chk("R4 level held", int'(level), D);
        chk("R4 full", int'(full), 1);

        // R8 clear warning while level high
        flag_clr = 1; tick(); settle();
        chk("R8 warn cleared", int'(warn), 0);

        // R10 start, read three, retry
        pkt_start = 1; tx_rd = 1; tick();
        rd(); rd();
        pkt_retry = 1; tx_rd = 1; tick(); settle();
        chk("R10 rewind head", int'(tx_data), 8'h10);
        chk("R10 rewind level", int'(level), D);

        // R11 acknowledge after four reads, then retry returns there
        pkt_start = 1; tx_rd = 1; tick();
        rd(); rd();
        pkt_ok = 1; tx_rd = 1; tick();
        rd();
        pkt_retry = 1; tick(); settle();
        chk("R11 resume head", int'(tx_data), 8'h14);

        // R12 simultaneous read and write across the wrap
        for (int i = 0; i < 3; i++) begin
            fw_wr = 1; fw_data = 8'h20 + 8'(i); tx_rd = 1; tick();
        end
        settle();
        chk("R12 level steady", int'(level), 4);

        // R6 drain and overrun the read side
        repeat (5) rd();
        settle();
        chk("R6 underrun set", int'(underrun), 1);
        chk("R7 warn low level", int'(warn), 1);
        flag_clr = 1; tick();
        tx_rd = 1; tx_last = 1; tick(); settle();
        chk("R6 last masks underrun", int'(underrun), 0);

        // R9 flush with a same-cycle write
        wr(8'h31); wr(8'h32); wr(8'h33);
        flush = 1; fw_wr = 1; fw_data = 8'h99; tx_rd = 1; tick(); settle();
        chk("R9 flushed", int'(level), 0);

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int c = 0; c < 600; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fw_wr     = lfsr[0] | lfsr[1];
            fw_data   = lfsr[15:8];
            tx_rd     = lfsr[2] | lfsr[3];
            tx_last   = lfsr[4];
            pkt_start = (lfsr[7:5] == 3'd0);
            pkt_ok    = (lfsr[7:5] == 3'd1);
            pkt_retry = (lfsr[7:5] == 3'd2) && (m_wp - m_anc + 1 <= D);
            flag_clr  = (lfsr[11:9] == 3'd0);
            flush     = (lfsr[14:8] == 7'd0);
            tick();
        end

        settle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule